// File: doc/BRIEF.md
# Serial Skew-Delay Code Register Slave

This block is a serial peripheral slave that lets a host set and read back three 6-bit delay codes, one each for the red, green and blue paths of a skew-compensating video delay line. The serial pins (clock, data in, active-low select) are brought into a fast system clock domain through synchronizer flops, and the block finds the serial clock edges by sampling them there. The block drives the serial data output and presents the three stored codes to downstream delay logic as plain parallel buses.

Each transaction is a fixed 16-bit frame, sent most significant bit first and captured on rising serial clock edges. The first byte carries a direction flag and a channel select. On a write, the second byte supplies the new code, which takes effect only when the select line is released after a complete frame. On a read, the stored code is shifted out during the last six bit times of that same frame.

Top module: `dly_spi_regs`

## Requirements
- R1: After reset all three delay outputs are 0 and the serial data output is low.
- R2: A write frame has the first-byte bit 7 = 0 and the channel select in first-byte bits 1:0 (00 red, 01 green, 10 blue). The code is in second-byte bits 5:0. Both bytes are sent MSB first. The selected output takes the code once the select line rises after exactly 16 rising clock edges, and the other two outputs keep their values.
- R3: Second-byte bits 7:6 have no effect on the stored code.
- R4: In a read frame (first-byte bit 7 = 1), bit times are numbered 0 to 15, and bit time n is the one the host samples on rising edge n. Bit times 10 to 15 carry the stored code of the selected channel, MSB first. Bit times 0 to 9 are low, and the read leaves all three outputs unchanged.
- R5: Select value 11 addresses no channel. A write with it changes no output, and a read with it returns all zeros.
- R6: A frame with fewer than 16 rising clock edges before the select line rises changes no output.
- R7: A frame with more than 16 rising clock edges changes no output.
- R8: The serial data output is low while the select line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock from host |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_csn_i | input | 1 | Active-low select from host |
| spi_miso_o | output | 1 | Serial data to host |
| red_dly_o | output | CODE_W | Stored red delay code |
| grn_dly_o | output | CODE_W | Stored green delay code |
| blu_dly_o | output | CODE_W | Stored blue delay code |

## Verification
Every one of the 64 codes is written to each of the three channels and then read back. In each write, the two don't-care bits carry a pattern that changes from frame to frame. This sweep separates wrong channel decoding, bit-order errors and leakage of the don't-care bits into the code, and the three outputs are compared against a model after every frame. Frames cut off after 1, 8, 12 and 15 edges, and a frame stretched to 17 edges, check that commitment depends on the exact length. Writes and reads with the unused select value show that no fourth register exists. The worked examples, code 42 written to green and code 21 read from blue, fix the bit order and the read timing.

// File: rtl/dly_spi_pkg.sv
package dly_spi_pkg;
  localparam int NUM_CH     = 3;
  localparam int BYTE_BITS  = 8;
  localparam int FRAME_BITS = 2 * BYTE_BITS;

  typedef enum logic [1:0] {
    SEL_RED   = 2'b00,
    SEL_GREEN = 2'b01,
    SEL_BLUE  = 2'b10,
    SEL_NONE  = 2'b11
  } chan_sel_e;
endpackage

// File: rtl/dly_pin_sync.sv
module dly_pin_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = g_stg[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end
  end

  assign sync_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/dly_spi_frame.sv
module dly_spi_frame
  import dly_spi_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic [1:0]        rd_sel_o,
  output logic              wr_en_o,
  output logic [1:0]        wr_sel_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              miso_o
);
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX    = FRAME_BITS + 1;
  localparam int DATA_FIRST = FRAME_BITS - CODE_W;
  localparam int SHIFT_W    = BYTE_BITS - 1;

  logic                 sck_q, csn_q;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [SHIFT_W-1:0]   shift_q, shift_d;
  logic                 rw_q, rw_d;
  logic [1:0]           sel_q, sel_d;
  logic [CODE_W-1:0]    buf_q, buf_d;
  logic                 miso_q, miso_d;

  logic                 sck_rise, cs_fall, cs_rise;
  logic [CNT_W-1:0]     tail_idx;
  logic [CODE_W-1:0]    tail_shift;
  logic                 in_data;

  assign sck_rise = sck_s & ~sck_q & ~csn_s;
  assign cs_fall  = ~csn_s & csn_q;
  assign cs_rise  = csn_s & ~csn_q;

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = shift_q;
    rw_d    = rw_q;
    sel_d   = sel_q;
    buf_d   = buf_q;
    if (cs_fall) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      shift_d = {shift_q[SHIFT_W-2:0], mosi_s};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(BYTE_BITS - 1)) begin
        rw_d  = shift_q[SHIFT_W-1];
        sel_d = {shift_q[0], mosi_s};
      end
    end
    if (cnt_q == CNT_W'(BYTE_BITS)) begin
      buf_d = rw_q ? rd_code_i : '0;
    end
  end

  assign tail_idx   = CNT_W'(FRAME_BITS - 1) - cnt_q;
  assign tail_shift = buf_q >> tail_idx;
  assign in_data    = (cnt_q >= CNT_W'(DATA_FIRST)) && (cnt_q <= CNT_W'(FRAME_BITS - 1));
  assign miso_d     = ~csn_s & rw_q & in_data & tail_shift[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '0;
      rw_q    <= 1'b0;
      sel_q   <= 2'b00;
      buf_q   <= '0;
      miso_q  <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      csn_q   <= csn_s;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      rw_q    <= rw_d;
      sel_q   <= sel_d;
      buf_q   <= buf_d;
      miso_q  <= miso_d;
    end
  end

  assign rd_sel_o  = sel_q;
  assign wr_sel_o  = sel_q;
  assign wr_code_o = shift_q[CODE_W-1:0];
  assign wr_en_o   = cs_rise && (cnt_q == CNT_W'(FRAME_BITS)) && !rw_q && (sel_q != SEL_NONE);
  assign miso_o    = miso_q;

  // R6, R7: the edge counter advances by one per captured bit until it saturates
  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !cs_fall && cnt_q < CNT_W'(CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dly_code_bank.sv
module dly_code_bank
  import dly_spi_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [1:0]                     wr_sel_i,
  input  logic [CODE_W-1:0]              wr_code_i,
  input  logic [1:0]                     rd_sel_i,
  output logic [CODE_W-1:0]              rd_code_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  codes_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] d;
    logic [CODE_W-1:0] q;
    always_comb begin
      d = q;
      if (wr_en_i && (wr_sel_i == 2'(ch))) d = wr_code_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign codes_o[ch] = q;
  end

  always_comb begin
    rd_code_o = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (rd_sel_i == 2'(ch)) rd_code_o = codes_o[ch];
    end
  end

  // R6: nothing moves without a write strobe
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(codes_o));
  // R5: the unused select value addresses no storage
  a_r5_no_fourth_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_NONE) |=> $stable(codes_o));
endmodule

// File: rtl/dly_spi_regs.sv
module dly_spi_regs
  import dly_spi_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  input  logic              spi_csn_i,
  output logic              spi_miso_o,
  output logic [CODE_W-1:0] red_dly_o,
  output logic [CODE_W-1:0] grn_dly_o,
  output logic [CODE_W-1:0] blu_dly_o
);
  logic [2:0]                     pins_s;
  logic                           sck_s, mosi_s, csn_s;
  logic [1:0]                     rd_sel, wr_sel;
  logic                           wr_en;
  logic [CODE_W-1:0]              wr_code, rd_code;
  logic [NUM_CH-1:0][CODE_W-1:0]  codes;

  dly_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({spi_sck_i, spi_mosi_i, spi_csn_i}),
    .sync_o  (pins_s)
  );
  assign {sck_s, mosi_s, csn_s} = pins_s;

  dly_spi_frame #(.CODE_W(CODE_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .csn_s     (csn_s),
    .rd_code_i (rd_code),
    .rd_sel_o  (rd_sel),
    .wr_en_o   (wr_en),
    .wr_sel_o  (wr_sel),
    .wr_code_o (wr_code),
    .miso_o    (spi_miso_o)
  );

  dly_code_bank #(.CODE_W(CODE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_code_i (wr_code),
    .rd_sel_i  (rd_sel),
    .rd_code_o (rd_code),
    .codes_o   (codes)
  );

  assign red_dly_o = codes[SEL_RED];
  assign grn_dly_o = codes[SEL_GREEN];
  assign blu_dly_o = codes[SEL_BLUE];

  // R8: output stays low while deselected
  a_r8_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !spi_miso_o);
  // R2: outputs only change right after the select line has risen
  a_r2_update_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(codes) |-> $past(csn_s));
endmodule

// File: tb/tb_dly_spi_regs.sv
`timescale 1ns/1ps
module tb_dly_spi_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso;
  logic [5:0] red, grn, blu;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [5:0] exp_c [3];

  always #5 clk = ~clk;

  dly_spi_regs dut (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_mosi_i(mosi),
    .spi_csn_i(csn), .spi_miso_o(miso),
    .red_dly_o(red), .grn_dly_o(grn), .blu_dly_o(blu)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk(red == exp_c[0], {tag, " red"}, red, exp_c[0]);
    chk(grn == exp_c[1], {tag, " green"}, grn, exp_c[1]);
    chk(blu == exp_c[2], {tag, " blue"}, blu, exp_c[2]);
  endtask

  task automatic frame(input logic [7:0] b1, input logic [7:0] b2, input int nbits,
                       output logic [15:0] rx);
    logic [15:0] w;
    w = {b1, b2};
    rx = '0;
    csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (6) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    csn = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    for (int c = 0; c < 3; c++) exp_c[c] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_outs("R1 reset");
    chk(miso == 1'b0, "R1 sdo after reset", miso, 0);

    // R2 worked example: code 42 to green
    frame(8'h01, 8'h2A, 16, rx);
    exp_c[1] = 6'd42;
    chk_outs("R2 green 42");
    chk(miso == 1'b0, "R8 sdo idle", miso, 0);

    // R4 worked example: blue holds 21, read it back
    frame(8'h02, 8'h15, 16, rx);
    exp_c[2] = 6'd21;
    frame(8'h82, 8'h00, 16, rx);
    chk(rx == 16'd21, "R4 blue read 21", rx, 21);
    chk_outs("R4 read keeps outputs");

    // R2/R3/R4 sweep: every code on every channel
    for (int ch = 0; ch < 3; ch++) begin
      for (int code = 0; code < 64; code++) begin
        logic [1:0] junk;
        junk = 2'(code + ch);
        frame({6'b0, 2'(ch)}, {junk, 6'(code)}, 16, rx);
        exp_c[ch] = 6'(code);
        chk_outs("R2 R3 sweep write");
        frame({6'b100000, 2'(ch)}, 8'h00, 16, rx);
        chk(rx == 16'(code), "R4 sweep read", rx, code);
      end
      chk_outs("R4 after sweep");
    end

    // R5: select 11
    frame(8'h03, 8'h3F, 16, rx);
    chk_outs("R5 write sel 11");
    frame(8'h83, 8'h00, 16, rx);
    chk(rx == 16'd0, "R5 read sel 11", rx, 0);

    // R6: truncated frames
    frame(8'h00, 8'h15, 1, rx);
    chk_outs("R6 abort 1");
    frame(8'h01, 8'h15, 8, rx);
    chk_outs("R6 abort 8");
    frame(8'h02, 8'h15, 12, rx);
    chk_outs("R6 abort 12");
    frame(8'h00, 8'h2A, 15, rx);
    chk_outs("R6 abort 15");

    // R7: overlong frame
    frame(8'h01, 8'h11, 17, rx);
    chk_outs("R7 overlong");
    chk(miso == 1'b0, "R8 sdo idle end", miso, 0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule